// File: doc/BRIEF.md
# Four-Level Backplane Bus Arbiter

This block is the system-controller arbiter of a shared backplane that has four bus-request levels. On every clock it looks at the four active-low request lines and the active-low bus-busy line. When the bus is free it chooses one level and drives the active-low grant output of that level. Each grant output feeds the daisy chain for its level. The module that takes the bus asserts bus-busy, and the arbiter then withdraws the grant. The block does nothing unless a strap input, held low, marks this module as the system controller.

The scheme is chosen at run time. Single-level serves only the top level. Fixed priority serves the highest requesting level. Round-robin serves the level that follows the level served last. In priority mode the arbiter pulls bus-clear low when a level higher than the current owner is requesting, which asks the owner to give up the bus. A grant that nobody takes within a programmed number of cycles is withdrawn, and a one-cycle local interrupt reports the timeout.

The control is a three-state machine. In IDLE no grant is driven; IDLE goes to GRANT when a request is selected while the bus is free. GRANT drives one grant and goes to OWNED when bus-busy is seen, or back to IDLE when the timeout expires. OWNED waits for bus-busy to be released and then returns to IDLE. When the strap is high the machine is forced to IDLE.

Top module: `bp_arbiter`

## Requirements
- R1: While `sys_ctrl_n` is high, every grant stays high, `clear_n` stays high and `tmo_irq` stays low, whatever the other inputs do. Normal arbitration resumes on the first clock edge after the strap goes low.
- R2: A grant goes low only one clock edge after a cycle in which `busy_n` was high and a request was selected. At most one grant line is low at any time.
- R3: In fixed-priority mode (`mode` = 2'b01, and also 2'b11), the highest-numbered requesting level is granted. Level 3 has the highest priority and level 0 the lowest.
- R4: In single-level mode (`mode` = 2'b00), only a request on level 3 is granted. Requests on levels 0 to 2 are ignored, and their grants stay high.
- R5: In round-robin mode (`mode` = 2'b10), the requesting level granted is the first one found searching upward, modulo 4, from the level after the last level granted. Every grant in any mode updates the last-granted level. Reset sets it to 3, so the first search after reset starts at level 0.
- R6: In GRANT, if `busy_n` is low at a clock edge, the grant goes high after that edge. No new grant is issued while `busy_n` stays low.
- R7: If `busy_n` stays high, a grant is held for exactly `tmo_limit` cycles, with a value of 0 treated as 1. It is then withdrawn, and `tmo_irq` is high for the single following cycle.
- R8: In OWNED and in priority mode, `clear_n` is low whenever a level above the owner is requesting. It is never low in single-level or round-robin mode.
- R9: After reset all grants are high, `clear_n` is high and `tmo_irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sys_ctrl_n | input | 1 | Strap; low enables the arbiter |
| mode | input | 2 | 00 single-level, 01 priority, 10 round-robin, 11 priority |
| tmo_limit | input | TW | Grant timeout, in cycles |
| req_n | input | NLVL | Active-low bus requests, index = level |
| busy_n | input | 1 | Active-low bus-busy |
| grant_n | output | NLVL | Active-low grants, one per level |
| clear_n | output | 1 | Active-low bus-clear |
| tmo_irq | output | 1 | One-cycle timeout interrupt |

## Verification
The selection logic is swept with all sixteen request patterns under every mode encoding. Each expected level is computed from the scheme rules, so the sweep separates highest-wins from top-level-only and from rotation. Round-robin is swept twice with the last-granted level carried over from earlier grants, which shows that the rotation depends on history and not only on the current pattern. Separate sequences cover the following: requests while the bus is busy; grant hold times for timeout limits of 0 and 3; bus-clear with the owner below, above and equal to the new request in each mode; and the strap held off with every line requesting.

// File: rtl/bp_arb_pkg.sv
package bp_arb_pkg;

    typedef enum logic [1:0] {
        ARB_SINGLE   = 2'b00,
        ARB_PRIO     = 2'b01,
        ARB_RROBIN   = 2'b10,
        ARB_PRIO_ALT = 2'b11
    } arb_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_GRANT,
        ST_OWNED
    } arb_state_e;

endpackage

// File: rtl/bp_arb_select.sv
module bp_arb_select
    import bp_arb_pkg::*;
#(
    parameter int NLVL = 4,
    parameter int LW   = 2
) (
    input  logic [NLVL-1:0] req,
    input  logic [1:0]      mode,
    input  logic [LW-1:0]   last,
    output logic            hit,
    output logic [LW-1:0]   pick
);

    logic          prio_hit, rr_hit, top_hit;
    logic [LW-1:0] prio_lvl, rr_lvl;

    // fixed priority: highest index wins
    always_comb begin
        prio_hit = 1'b0;
        prio_lvl = '0;
        for (int i = 0; i < NLVL; i++) begin
            if (req[i]) begin
                prio_hit = 1'b1;
                prio_lvl = LW'(i);
            end
        end
    end

    // round-robin: first requester above the last one served, wrapping
    always_comb begin
        rr_hit = 1'b0;
        rr_lvl = '0;
        for (int k = 1; k <= NLVL; k++) begin
            int idx;
            idx = (int'(last) + k) % NLVL;
            if (!rr_hit && req[idx]) begin
                rr_hit = 1'b1;
                rr_lvl = LW'(idx);
            end
        end
    end

    assign top_hit = req[NLVL-1];

    always_comb begin
        unique case (arb_mode_e'(mode))
            ARB_SINGLE: begin
                hit  = top_hit;
                pick = LW'(NLVL-1);
            end
            ARB_RROBIN: begin
                hit  = rr_hit;
                pick = rr_lvl;
            end
            ARB_PRIO, ARB_PRIO_ALT: begin
                hit  = prio_hit;
                pick = prio_lvl;
            end
            default: begin
                hit  = 1'b0;
                pick = '0;
            end
        endcase
    end

endmodule

// File: rtl/bp_arb_timer.sv
module bp_arb_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [TW-1:0] limit,
    output logic          expire
);

    logic [TW-1:0] cnt;

    assign expire = run && (({1'b0, cnt} + (TW+1)'(1)) >= {1'b0, limit});

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (!expire) begin
            cnt <= cnt + TW'(1);
        end
    end

    // counter never passes the programmed window while a grant waits
    assert_cnt_in_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && limit != '0 && $stable(limit)) |-> (cnt < limit));

endmodule

// File: rtl/bp_arb_clear.sv
module bp_arb_clear
    import bp_arb_pkg::*;
#(
    parameter int NLVL = 4,
    parameter int LW   = 2
) (
    input  logic            owned,
    input  logic [1:0]      mode,
    input  logic [LW-1:0]   owner,
    input  logic [NLVL-1:0] req,
    output logic            clr
);

    logic [NLVL-1:0] above;
    logic            prio_mode;

    generate
        for (genvar g = 0; g < NLVL; g++) begin : g_above
            assign above[g] = req[g] && (LW'(g) > owner);
        end
    endgenerate

    assign prio_mode = (arb_mode_e'(mode) == ARB_PRIO) || (arb_mode_e'(mode) == ARB_PRIO_ALT);
    assign clr       = owned && prio_mode && (|above);

endmodule

// File: rtl/bp_arbiter.sv
module bp_arbiter
    import bp_arb_pkg::*;
#(
    parameter int NLVL = 4,
    parameter int TW   = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sys_ctrl_n,
    input  logic [1:0]      mode,
    input  logic [TW-1:0]   tmo_limit,
    input  logic [NLVL-1:0] req_n,
    input  logic            busy_n,
    output logic [NLVL-1:0] grant_n,
    output logic            clear_n,
    output logic            tmo_irq
);

    localparam int            LW   = (NLVL > 1) ? $clog2(NLVL) : 1;
    localparam logic [NLVL-1:0] ALL1 = {NLVL{1'b1}};

    arb_state_e    state, state_nx;
    logic [LW-1:0] owner, owner_nx;
    logic [LW-1:0] last, last_nx;
    logic          irq_nx;

    logic            enable, busy, hit, expire, clr;
    logic [NLVL-1:0] req;
    logic [LW-1:0]   pick;

    assign enable = ~sys_ctrl_n;
    assign busy   = ~busy_n;
    assign req    = ~req_n;

    bp_arb_select #(.NLVL(NLVL), .LW(LW)) u_sel (
        .req  (req),
        .mode (mode),
        .last (last),
        .hit  (hit),
        .pick (pick)
    );

    bp_arb_timer #(.TW(TW)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (enable && state == ST_GRANT && !busy),
        .limit  (tmo_limit),
        .expire (expire)
    );

    bp_arb_clear #(.NLVL(NLVL), .LW(LW)) u_clr (
        .owned (enable && state == ST_OWNED),
        .mode  (mode),
        .owner (owner),
        .req   (req),
        .clr   (clr)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        owner_nx = owner;
        last_nx  = last;
        irq_nx   = 1'b0;
        if (!enable) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (!busy && hit) begin
                        state_nx = ST_GRANT;
                        owner_nx = pick;
                        last_nx  = pick;
                    end
                end
                ST_GRANT: begin
                    if (busy) begin
                        state_nx = ST_OWNED;
                    end else if (expire) begin
                        state_nx = ST_IDLE;
                        irq_nx   = 1'b1;
                    end
                end
                ST_OWNED: begin
                    if (!busy) state_nx = ST_IDLE;
                end
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            owner   <= '0;
            last    <= LW'(NLVL-1);
            tmo_irq <= 1'b0;
        end else begin
            state   <= state_nx;
            owner   <= owner_nx;
            last    <= last_nx;
            tmo_irq <= irq_nx;
        end
    end

    // outputs
    always_comb begin
        grant_n = ALL1;
        if (enable && state == ST_GRANT) grant_n[owner] = 1'b0;
        clear_n = ~clr;
    end

    assert_one_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~grant_n) <= 1);

    assert_grant_on_free_bus_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(grant_n) == ALL1 && grant_n != ALL1) |-> $past(busy_n));

    assert_strap_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        sys_ctrl_n |-> (grant_n == ALL1 && clear_n));

    assert_release_on_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(grant_n) != ALL1 && !$past(busy_n)) |-> (grant_n == ALL1));

    assert_tmo_after_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_irq |-> ($past(grant_n) != ALL1 && $past(busy_n) && grant_n == ALL1));

    assert_clear_prio_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_n |-> (mode[0] && busy_n == 1'b0 || mode[0] && $past(!busy_n)));

    assert_single_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(grant_n) == ALL1 && grant_n != ALL1 && $past(mode) == 2'b00)
            |-> (grant_n[NLVL-1] == 1'b0));

endmodule

// File: tb/sim_bp_arbiter.sv
module sim_bp_arbiter;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       sys_ctrl_n;
    logic [1:0] mode;
    logic [7:0] tmo_limit;
    logic [3:0] req_n;
    logic       busy_n;
    logic [3:0] grant_n;
    logic       clear_n;
    logic       tmo_irq;

    int tests = 0;
    int fails = 0;
    int last_m = 3;
    bit done = 0;

    always #5 clk = ~clk;

    bp_arbiter #(.NLVL(4), .TW(8)) u0 (
        .clk(clk), .rst_n(rst_n), .sys_ctrl_n(sys_ctrl_n), .mode(mode),
        .tmo_limit(tmo_limit), .req_n(req_n), .busy_n(busy_n),
        .grant_n(grant_n), .clear_n(clear_n), .tmo_irq(tmo_irq)
    );

    task automatic chk(string tag, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic int exp_pick(int m, int pat, int last);
        int r = -1;
        if (m == 0) begin
            if (pat[3]) r = 3;
        end else if (m == 2) begin
            for (int k = 1; k <= 4; k++) begin
                int idx = (last + k) % 4;
                if (r < 0 && pat[idx]) r = idx;
            end
        end else begin
            for (int i = 0; i < 4; i++) if (pat[i]) r = i;
        end
        return r;
    endfunction

    function automatic int gexp(int lvl);
        return (lvl < 0) ? 4'hF : (~(4'b0001 << lvl)) & 4'hF;
    endfunction

    task automatic trial(int m, int pat);
        int e;
        string tag;
        @(negedge clk);
        mode = 2'(m); req_n = ~4'(pat); busy_n = 1'b1;
        e = exp_pick(m, pat, last_m);
        tag = (m == 0) ? "R4 single" : (m == 2) ? "R5 rrobin" : "R3 prio";
        @(negedge clk);
        chk(tag, grant_n, gexp(e));
        if (e >= 0) begin
            last_m = e;
            busy_n = 1'b0;
            @(negedge clk);
            chk("R6 release", grant_n, 4'hF);
            req_n = 4'hF; busy_n = 1'b1;
            @(negedge clk);
        end else begin
            req_n = 4'hF;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; sys_ctrl_n = 1'b0; mode = 2'b01; tmo_limit = 8'd20;
        req_n = 4'hF; busy_n = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 grant", grant_n, 4'hF);
        chk("R9 clear", clear_n, 1);
        chk("R9 irq", tmo_irq, 0);

        // exhaustive sweep of patterns x modes; round-robin twice
        for (int m = 0; m < 4; m++)
            for (int p = 0; p < 16; p++) trial(m, p);
        for (int p = 0; p < 16; p++) trial(2, p);
        for (int p = 15; p >= 0; p--) trial(2, p);

        // R6: no grant while the bus is busy
        @(negedge clk);
        mode = 2'b01; busy_n = 1'b0; req_n = 4'b0111;
        repeat (3) begin
            @(negedge clk);
            chk("R6 busy hold", grant_n, 4'hF);
        end
        busy_n = 1'b1;
        @(negedge clk);
        chk("R2 grant after free", grant_n, 4'b0111);
        busy_n = 1'b0;
        @(negedge clk);
        req_n = 4'hF; busy_n = 1'b1;
        @(negedge clk);

        // R7: timeout with limit 3 and with limit 0
        for (int t = 0; t < 2; t++) begin
            int lim = (t == 0) ? 3 : 0;
            int hold = (lim == 0) ? 1 : lim;
            tmo_limit = 8'(lim); mode = 2'b01; req_n = 4'b1011;
            for (int c = 0; c < hold; c++) begin
                @(negedge clk);
                chk("R7 hold grant", grant_n, 4'b1011);
                chk("R7 no irq yet", tmo_irq, 0);
            end
            @(negedge clk);
            chk("R7 withdrawn", grant_n, 4'hF);
            chk("R7 irq", tmo_irq, 1);
            req_n = 4'hF;
            @(negedge clk);
            chk("R7 irq pulse", tmo_irq, 0);
        end
        tmo_limit = 8'd20;

        // R8: bus-clear with owner at level 1
        for (int m = 0; m < 4; m++) begin
            @(negedge clk);
            mode = 2'b01; req_n = 4'b1101;
            @(negedge clk);
            busy_n = 1'b0;
            @(negedge clk);
            mode = 2'(m);
            #1 chk("R8 owner only", clear_n, 1);
            @(negedge clk);
            req_n = 4'b1100; #1 chk("R8 lower req", clear_n, 1);
            @(negedge clk);
            req_n = 4'b0101; #1 chk("R8 higher req", clear_n, (m == 0 || m == 2) ? 1 : 0);
            @(negedge clk);
            req_n = 4'hF; busy_n = 1'b1;
            #1 chk("R8 released", clear_n, 1);
            @(negedge clk);
        end

        // R1: strap off blocks everything
        @(negedge clk);
        sys_ctrl_n = 1'b1; mode = 2'b01; tmo_limit = 8'd1; req_n = 4'h0;
        repeat (4) begin
            @(negedge clk);
            chk("R1 no grant", grant_n, 4'hF);
            chk("R1 no irq", tmo_irq, 0);
            chk("R1 no clear", clear_n, 1);
        end
        sys_ctrl_n = 1'b0;
        @(negedge clk);
        chk("R1 resumes", grant_n, 4'b0111);
        req_n = 4'hF;
        repeat (3) @(negedge clk);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule